// File: doc/BRIEF.md
# Hamming Sub-Page Error Corrector

This block repairs a page buffer after a flash page read. For each 256-byte half of the page it receives two 22-bit single-error-correcting Hamming codes: the code kept in the spare area (stored) and the code recomputed from the data as it arrived (calculated). It XORs them into a syndrome and sorts the result into one of four outcomes: clean, a fault confined to the code bytes, a single data bit that can be repaired, or damage beyond repair. When a data bit can be repaired, the block reads the affected byte through a byte-wide synchronous memory port, flips the bit and writes the byte back.

A pulse on `start` captures the codes and the page-size selection. In 256-byte mode only the first code pair is examined. In 512-byte mode the second pair covers bytes 256 to 511 of the buffer. The failure flags of the two halves are ORed into `fail`. The block always takes the same number of cycles for a given page size, so a sequencer can schedule the next page without polling.

Top module: `hecc_fixer`

## Requirements
- R1: Each code input holds three bytes with the first byte in bits 7:0. Bits 10:0 are the parity word and bits 21:11 are the complement parity word. Bits 23:22 are ignored.
- R2: If the syndrome (calculated XOR stored) is zero, or either code is zero, the status is 2'b00 and the buffer is not written.
- R3: If the syndrome has exactly one bit set, the status is 2'b01 and the buffer is not written.
- R4: If the syndrome has exactly 11 bits set and its low 11 bits XOR its high 11 bits equal 11'h7FF, the status is 2'b10. The byte index is syndrome bits 10:3 and the bit index is syndrome bits 2:0. For every other status both indices read zero.
- R5: For status 2'b10, the byte at address half*256 + byte index is read and written back with only the indexed bit inverted. No other buffer location changes.
- R6: Every syndrome not covered by R2 to R4 gives status 2'b11 and leaves the buffer untouched.
- R7: When `wide_page` is 1 at start, the second code pair is classified and corrected in the same way, using addresses 256 to 511.
- R8: `fail` is 1 exactly when a processed half has status 2'b01 or 2'b11. In 256-byte mode the second half reports status 2'b00 and zero indices, and its codes have no effect.
- R9: `done` pulses for one cycle, 2 cycles after the start edge in 256-byte mode and 4 cycles after it in 512-byte mode. A `start` that arrives while a run is in progress is ignored.
- R10: After reset, `done`, `mem_rd`, `mem_wr`, `fail` and both statuses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a run while the block is idle |
| wide_page | input | 1 | 1 selects 512-byte pages (two halves) |
| calc_a | input | 24 | Calculated code, first half |
| stored_a | input | 24 | Stored code, first half |
| calc_b | input | 24 | Calculated code, second half |
| stored_b | input | 24 | Stored code, second half |
| done | output | 1 | One-cycle pulse marking valid results |
| status_a | output | 2 | Outcome of first half |
| status_b | output | 2 | Outcome of second half |
| byte_a | output | 8 | Failing byte index, first half |
| bit_a | output | 3 | Failing bit index, first half |
| byte_b | output | 8 | Failing byte index, second half |
| bit_b | output | 3 | Failing bit index, second half |
| fail | output | 1 | OR of the per-half failure flags |
| mem_addr | output | 9 | Page buffer byte address |
| mem_rd | output | 1 | Buffer read strobe; data returns the next cycle |
| mem_rdata | input | 8 | Buffer read data |
| mem_wr | output | 1 | Buffer write strobe |
| mem_wdata | output | 8 | Buffer write data |

## Verification
Status, indices and `fail` are loaded on the start edge, and `done` follows 2 or 4 edges later. The bench samples on falling edges and checks `done` low one cycle before its due edge and high on it. It reads the results in that same half cycle. Read data from the modelled buffer arrives one edge after `mem_rd`, so the write that follows is complete before `done` is seen. The whole 512-byte buffer is compared with its expected image only after `done`.

// File: rtl/hecc_fixer.sv
module hecc_fixer #(
  parameter int PAR_W = 11,
  localparam int CODE_W = 2 * PAR_W,
  localparam int IN_W = 8 * ((CODE_W + 7) / 8),
  localparam int BYTE_W = PAR_W - 3,
  localparam int ADDR_W = PAR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wide_page,
  input  logic [IN_W-1:0]   calc_a,
  input  logic [IN_W-1:0]   stored_a,
  input  logic [IN_W-1:0]   calc_b,
  input  logic [IN_W-1:0]   stored_b,
  output logic              done,
  output logic [1:0]        status_a,
  output logic [1:0]        status_b,
  output logic [BYTE_W-1:0] byte_a,
  output logic [2:0]        bit_a,
  output logic [BYTE_W-1:0] byte_b,
  output logic [2:0]        bit_b,
  output logic              fail,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [7:0]        mem_rdata,
  output logic              mem_wr,
  output logic [7:0]        mem_wdata
);

  typedef enum logic [1:0] {IDLE, RD, WR} state_t;

  state_t           state;
  logic             half;
  logic             wide_q;
  logic [PAR_W-1:0] loc_a, loc_b;

  function automatic logic [1:0] classify(input logic [CODE_W-1:0] c, input logic [CODE_W-1:0] s);
    logic [CODE_W-1:0] syn;
    logic [PAR_W-1:0]  pair;
    syn  = c ^ s;
    pair = (c[PAR_W-1:0] ^ c[CODE_W-1:PAR_W]) ^ (s[PAR_W-1:0] ^ s[CODE_W-1:PAR_W]);
    if (syn == '0 || c == '0 || s == '0) return 2'b00;
    if ($countones(syn) == 1) return 2'b01;
    if ($countones(syn) == PAR_W && pair == '1) return 2'b10;
    return 2'b11;
  endfunction

  logic [1:0]       cls_a, cls_b;
  logic [PAR_W-1:0] syn_a, syn_b;

  assign cls_a = classify(calc_a[CODE_W-1:0], stored_a[CODE_W-1:0]);
  assign cls_b = classify(calc_b[CODE_W-1:0], stored_b[CODE_W-1:0]);
  assign syn_a = calc_a[PAR_W-1:0] ^ stored_a[PAR_W-1:0];
  assign syn_b = calc_b[PAR_W-1:0] ^ stored_b[PAR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= IDLE;
      half     <= 1'b0;
      wide_q   <= 1'b0;
      done     <= 1'b0;
      status_a <= 2'b00;
      status_b <= 2'b00;
      loc_a    <= '0;
      loc_b    <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        IDLE: if (start) begin
          state    <= RD;
          half     <= 1'b0;
          wide_q   <= wide_page;
          status_a <= cls_a;
          loc_a    <= (cls_a == 2'b10) ? syn_a : '0;
          status_b <= wide_page ? cls_b : 2'b00;
          loc_b    <= (wide_page && cls_b == 2'b10) ? syn_b : '0;
        end
        RD: state <= WR;
        WR: if (!half && wide_q) begin
          half  <= 1'b1;
          state <= RD;
        end else begin
          state <= IDLE;
          done  <= 1'b1;
        end
        default: state <= IDLE;
      endcase
    end
  end

  logic [PAR_W-1:0] cur_loc;
  logic             fix;

  assign cur_loc   = half ? loc_b : loc_a;
  assign fix       = (half ? status_b : status_a) == 2'b10;
  assign mem_addr  = {half, cur_loc[PAR_W-1:3]};
  assign mem_rd    = (state == RD) && fix;
  assign mem_wr    = (state == WR) && fix;
  assign mem_wdata = mem_rdata ^ (8'd1 << cur_loc[2:0]);

  assign byte_a = loc_a[PAR_W-1:3];
  assign bit_a  = loc_a[2:0];
  assign byte_b = loc_b[PAR_W-1:3];
  assign bit_b  = loc_b[2:0];
  assign fail   = status_a[0] | status_b[0];

endmodule

// File: rtl/hecc_fixer_chk.sv
module hecc_fixer_chk #(
  parameter int PAR_W = 11,
  localparam int ADDR_W = PAR_W - 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic [1:0]        status_a,
  input logic [1:0]        status_b,
  input logic              fail,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd,
  input logic              mem_wr
);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

  a_r5_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> ($past(mem_rd) && mem_addr == $past(mem_addr)));

  a_r5_read_then_write: assert property (@(posedge clk) disable iff (!rst_n) mem_rd |=> mem_wr);

  a_r4_low_write_needs_fix: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_addr[ADDR_W-1]) |-> status_a == 2'b10);

  a_r7_high_write_needs_fix: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && mem_addr[ADDR_W-1]) |-> status_b == 2'b10);

  a_r8_fail_flag: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> fail == (status_a == 2'b01 || status_a == 2'b11 || status_b == 2'b01 || status_b == 2'b11));

  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr));

endmodule

bind hecc_fixer hecc_fixer_chk #(.PAR_W(PAR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .status_a(status_a), .status_b(status_b),
  .fail(fail), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr)
);

// File: tb/hecc_fixer_bench.sv
`timescale 1ns/100ps
module hecc_fixer_bench;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, wide_page = 1'b0;
  logic [23:0] calc_a = '0, stored_a = '0, calc_b = '0, stored_b = '0;
  logic done, fail, mem_rd, mem_wr;
  logic [1:0] status_a, status_b;
  logic [7:0] byte_a, byte_b, mem_rdata, mem_wdata;
  logic [2:0] bit_a, bit_b;
  logic [8:0] mem_addr;

  always #2.5 clk = ~clk;

  hecc_fixer u_hecc_fixer (
    .clk(clk), .rst_n(rst_n), .start(start), .wide_page(wide_page),
    .calc_a(calc_a), .stored_a(stored_a), .calc_b(calc_b), .stored_b(stored_b),
    .done(done), .status_a(status_a), .status_b(status_b),
    .byte_a(byte_a), .bit_a(bit_a), .byte_b(byte_b), .bit_b(bit_b), .fail(fail),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata)
  );

  logic [7:0] ram [512];
  logic [7:0] want [512];
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= ram[mem_addr];
    if (mem_wr) ram[mem_addr] <= mem_wdata;
  end

  localparam int NV = 12;
  localparam logic        MODE [NV] = '{0,0,0,0,0,0,0,1,1,0,0,0};
  localparam logic [23:0] CA [NV] = '{24'h1A2B3C,24'h1A2B3C,24'h1A2B3C,24'h1A2B3C,24'h1A2B3C,24'h1A2B3C,
                                      24'h000000,24'h1A2B3C,24'h1A2B3C,24'h1A2B3C,24'h1A2B3C,24'h1A2B3C};
  localparam logic [23:0] SA [NV] = '{24'h1A2B3C,24'h1A2F3C,24'h2CB210,24'h25D33C,24'h1A2CC3,24'h1A2B3F,
                                      24'h123456,24'h25FB39,24'h1A2B3C,24'h1A20C3,24'hDA2B3C,24'h1A2B3C};
  localparam logic [23:0] CB [NV] = '{0,0,0,0,0,0,0,24'h05A5A5,24'h05A5A5,0,0,24'h05A5A5};
  localparam logic [23:0] SB [NV] = '{0,0,0,0,0,0,0,24'h2A5FA5,24'h05A5A2,0,0,24'h05A5A6};
  localparam logic [1:0]  XA [NV] = '{0,1,2,2,2,3,0,2,0,3,0,0};
  localparam logic [1:0]  XB [NV] = '{0,0,0,0,0,0,0,2,3,0,0,0};
  localparam logic [10:0] PA [NV] = '{0,0,300,0,2047,0,0,5,0,0,0,0};
  localparam logic [10:0] PB [NV] = '{0,0,0,0,0,0,0,512,0,0,0,0};

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill_ram();
    for (int i = 0; i < 512; i++) begin
      ram[i] = 8'(i * 37 + 11);
      want[i] = ram[i];
    end
  endtask

  task automatic check_ram(input string req);
    int diffs = 0;
    for (int i = 0; i < 512; i++) if (ram[i] !== want[i]) diffs++;
    chk(req, diffs, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    fill_ram();
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 done", done, 0);
    chk("R10 strobes", {mem_rd, mem_wr}, 0);
    chk("R10 status", {status_a, status_b, fail}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      int cyc;
      fill_ram();
      wide_page = MODE[v];
      calc_a = CA[v]; stored_a = SA[v]; calc_b = CB[v]; stored_b = SB[v];
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = MODE[v] ? 4 : 2;
      repeat (cyc - 1) @(negedge clk);
      chk("R9 done early", done, 0);
      @(negedge clk);
      chk("R9 done due", done, 1);
      // R2 R3 R4 R6 classification of first half
      chk("R4 status_a", status_a, XA[v]);
      chk("R4 byte_a", byte_a, (XA[v] == 2) ? PA[v][10:3] : 8'd0);
      chk("R4 bit_a", bit_a, (XA[v] == 2) ? PA[v][2:0] : 3'd0);
      // R7 second half, R8 ignored when narrow
      chk("R7 status_b", status_b, XB[v]);
      chk("R7 byte_b", byte_b, (XB[v] == 2) ? PB[v][10:3] : 8'd0);
      chk("R7 bit_b", bit_b, (XB[v] == 2) ? PB[v][2:0] : 3'd0);
      chk("R8 fail", fail, (XA[v] == 1 || XA[v] == 3 || XB[v] == 1 || XB[v] == 3));
      if (XA[v] == 2) want[PA[v][10:3]] ^= 8'(1 << PA[v][2:0]);
      if (XB[v] == 2) want[256 + PB[v][10:3]] ^= 8'(1 << PB[v][2:0]);
      // R5 buffer image after correction; R1 top bits ignored in v10
      check_ram((v == 10) ? "R1 buffer" : "R5 buffer");
      @(negedge clk);
      chk("R9 done single", done, 0);
    end

    // R9 start held while busy is ignored
    fill_ram();
    wide_page = 1'b0; calc_a = 24'h1A2B3C; stored_a = 24'h2CB210;
    start = 1'b1;
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk("R9 held start done", done, 1);
    @(negedge clk);
    chk("R9 held start no repeat", done, 0);
    @(negedge clk);
    chk("R9 held start no second run", done, 0);
    want[37] ^= 8'h10;
    check_ram("R9 single correction");

    finish_run();
  end
endmodule